// File: doc/BRIEF.md
# ADC Result Sequencer with Threshold Compare

This block is the digital back end of a multi-conversion analog-to-digital sequence. A pulse on `seq_start` opens a sequence; each conversion result then arrives on a valid/data pair. A 4-bit conversion counter picks which of sixteen result registers receives each result. In parallel, a conversion number counts the results inside the current sequence from zero.

For any conversion number whose compare-enable bit is set, the block does not store the result. It compares the result against a threshold that software placed earlier in the destination register. A per-conversion sense bit picks the direction of the test, and a sticky flag records each compare that succeeds. In FIFO mode the counter keeps advancing across the sequences of a looping scan. Starting a sequence or aborting one always brings the counter back to zero.

A simple register port gives access to the result registers, control, compare-enable mask, sense mask, flags and counter. Reads are combinational and writes take effect at the clock edge.

Top module: `adc_seq_cmp`

## Requirements
- R1: After synchronous reset, every readable address (0 to 31) reads zero and `seq_done` is low.
- R2: A start pulse zeroes the counter and the conversion number and opens a sequence, also in FIFO mode. A result presented in the same cycle as the start is dropped.
- R3: An accepted result whose conversion number has compare disabled is written to the result register selected by the counter. The counter then advances by one and wraps from 15 to 0.
- R4: With control bit 0 (FIFO) clear, the counter reads zero after the last conversion of a sequence.
- R5: With FIFO set and control bit 1 (loop) set, the scan continues into the next sequence without a start. The counter keeps advancing across sequence boundaries and wraps.
- R6: A sequence holds control bits 7:4 plus one conversions. `seq_done` is high for exactly the one cycle after the last result is accepted. Results that arrive while no sequence is open change no state.
- R7: Any write to the compare-enable register (address 17) aborts the open sequence and zeroes the counter. Later results are ignored until the next start.
- R8: Compare-enable bit n (address 17) and sense bit n (address 18) apply to conversion number n within the sequence, not to the counter value. A success sets flag bit n (address 19).
- R9: The threshold is the content of the result register selected by the counter. With sense 1 the compare succeeds when result > threshold. With sense 0 it succeeds when result <= threshold.
- R10: A compared conversion leaves the threshold in its result register.
- R11: Writing 1 to a bit of the flag register (address 19) clears that flag. A set and a clear of the same flag in one cycle leave it set.
- R12: Addresses 0 to 15 are result registers holding 12 bits and reading zero above bit 11. Address 16 is control, and address 20 reads the counter in bits 3:0 and ignores writes. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | One-cycle pulse that opens a sequence |
| res_valid | input | 1 | Conversion result present this cycle |
| res_data | input | 12 | Conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| seq_done | output | 1 | One-cycle pulse after the last conversion of a sequence |

## Verification
Sequence lengths are swept from one to sixteen in single-shot non-FIFO mode. This separates an off-by-one in the length compare from a counter that fails to return to zero, because every register index and every done position is seen. A looping FIFO run of twenty results crosses the 15-to-0 wrap, so it shows whether later results overwrite the earliest registers. A two-conversion FIFO loop with compare enabled on conversion 1 only separates indexing by conversion number from indexing by counter. Compare results are swept at and around a threshold of 100 for both sense values, which pins down the strict and non-strict boundaries. Collisions are driven on purpose (start with a result, flag clear with a flag set, abort followed by results) to fix the priority rules.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int NUM_CONV = 16;
    localparam int CNT_W    = $clog2(NUM_CONV);
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 5;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'd16;
    localparam logic [ADDR_W-1:0] A_CMPE  = 5'd17;
    localparam logic [ADDR_W-1:0] A_SENSE = 5'd18;
    localparam logic [ADDR_W-1:0] A_FLAG  = 5'd19;
    localparam logic [ADDR_W-1:0] A_CNT   = 5'd20;

    typedef struct packed {
        logic [CNT_W-1:0] len_m1;
        logic [1:0]       rsvd;
        logic             loop;
        logic             fifo;
    } ctrl_t;

    typedef struct packed {
        logic             fire;
        logic [CNT_W-1:0] slot;
        logic [CNT_W-1:0] num;
    } accept_t;

    function automatic logic cmp_pass(input logic sense,
                                      input logic [REG_W-1:0] res,
                                      input logic [REG_W-1:0] thr);
        return sense ? (res > thr) : (res <= thr);
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             res_valid,
    input  ctrl_t            ctrl,
    output accept_t          acc,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             done
);

    logic [CNT_W-1:0] num_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic             last;

    assign last     = (num_q == ctrl.len_m1);
    assign acc.fire = res_valid && busy_q && !start && !abort;
    assign acc.slot = cnt_q;
    assign acc.num  = num_q;
    assign cnt      = cnt_q;
    assign busy     = busy_q;
    assign done     = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
                num_q  <= '0;
            end else if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                num_q  <= '0;
            end else if (acc.fire) begin
                if (last) begin
                    num_q  <= '0;
                    done_q <= 1'b1;
                    busy_q <= ctrl.loop;
                    cnt_q  <= ctrl.fifo ? cnt_q + 1'b1 : '0;
                end else begin
                    num_q <= num_q + 1'b1;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        abort |=> (cnt == '0 && !busy)); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && !abort) |=> (cnt == '0 && acc.num == '0 && busy)); // R2
    AST_NONFIFO_END_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc.fire && last && !ctrl.fifo) |=> (cnt == '0)); // R4
    AST_FIFO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (acc.fire && ctrl.fifo) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R5
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
        (acc.fire && !last) |=> !done); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(cnt)); // R6

endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  accept_t                         acc,
    input  logic [RES_W-1:0]                res_data,
    input  logic [NUM_CONV-1:0]             cmpe,
    input  logic [NUM_CONV-1:0]             sense,
    input  logic                            sw_wr,
    input  logic [CNT_W-1:0]                sw_idx,
    input  logic [RES_W-1:0]                sw_data,
    input  logic [NUM_CONV-1:0]             flag_clr,
    output logic [NUM_CONV-1:0][RES_W-1:0]  res_q,
    output logic [NUM_CONV-1:0]             flags
);

    logic [RES_W-1:0] thr;
    logic             cmp_on;
    logic             hit;
    logic             store_on;

    assign thr      = res_q[acc.slot];
    assign cmp_on   = acc.fire && cmpe[acc.num];
    assign store_on = acc.fire && !cmpe[acc.num];
    assign hit      = cmp_on && cmp_pass(sense[acc.num], REG_W'(res_data), REG_W'(thr));

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CONV; i++) begin
            if (rst) begin
                res_q[i] <= '0;
            end else if (store_on && acc.slot == CNT_W'(i)) begin
                res_q[i] <= res_data;
            end else if (sw_wr && sw_idx == CNT_W'(i)) begin
                res_q[i] <= sw_data;
            end
        end
    end

    for (genvar n = 0; n < NUM_CONV; n++) begin : g_flag
        logic set_n;
        assign set_n = hit && (acc.num == CNT_W'(n));
        always_ff @(posedge clk) begin
            if (rst)               flags[n] <= 1'b0;
            else if (set_n)        flags[n] <= 1'b1;
            else if (flag_clr[n])  flags[n] <= 1'b0;
        end
    end

    AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (rst)
        store_on |=> (res_q[$past(acc.slot)] == $past(res_data))); // R3
    AST_THRESH_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cmp_on && !(sw_wr && sw_idx == acc.slot)) |=> (res_q[$past(acc.slot)] == $past(thr))); // R10
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        hit |=> flags[$past(acc.num)]); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!acc.fire && flag_clr == '0) |=> $stable(flags)); // R11

endmodule

// File: rtl/adc_seq_cmp.sv
module adc_seq_cmp
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_start,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              seq_done
);

    ctrl_t                           ctrl_q;
    logic [NUM_CONV-1:0]             cmpe_q;
    logic [NUM_CONV-1:0]             sense_q;
    logic [NUM_CONV-1:0]             flags;
    logic [NUM_CONV-1:0][RES_W-1:0]  res_q;
    logic [NUM_CONV-1:0]             flag_clr;
    accept_t                         acc;
    logic [CNT_W-1:0]                cnt;
    logic                            busy;
    logic                            abort;
    logic                            sw_wr;

    assign abort    = reg_wr && reg_addr == A_CMPE;
    assign sw_wr    = reg_wr && reg_addr < ADDR_W'(NUM_CONV);
    assign flag_clr = (reg_wr && reg_addr == A_FLAG) ? reg_wdata[NUM_CONV-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cmpe_q  <= '0;
            sense_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  ctrl_q  <= '{len_m1: reg_wdata[7:4], rsvd: 2'b00,
                                      loop: reg_wdata[1], fifo: reg_wdata[0]};
                A_CMPE:  cmpe_q  <= reg_wdata[NUM_CONV-1:0];
                A_SENSE: sense_q <= reg_wdata[NUM_CONV-1:0];
                default: ;
            endcase
        end
    end

    adc_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (seq_start),
        .abort     (abort),
        .res_valid (res_valid),
        .ctrl      (ctrl_q),
        .acc       (acc),
        .cnt       (cnt),
        .busy      (busy),
        .done      (seq_done)
    );

    adc_seq_store #(.RES_W(RES_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .res_data (res_data),
        .cmpe     (cmpe_q),
        .sense    (sense_q),
        .sw_wr    (sw_wr),
        .sw_idx   (reg_addr[CNT_W-1:0]),
        .sw_data  (reg_wdata[RES_W-1:0]),
        .flag_clr (flag_clr),
        .res_q    (res_q),
        .flags    (flags)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < ADDR_W'(NUM_CONV)) begin
            reg_rdata = REG_W'(res_q[reg_addr[CNT_W-1:0]]);
        end else begin
            case (reg_addr)
                A_CTRL:  reg_rdata = REG_W'(ctrl_q);
                A_CMPE:  reg_rdata = REG_W'(cmpe_q);
                A_SENSE: reg_rdata = REG_W'(sense_q);
                A_FLAG:  reg_rdata = REG_W'(flags);
                A_CNT:   reg_rdata = REG_W'(cnt);
                default: reg_rdata = '0;
            endcase
        end
    end

    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (seq_done && !ctrl_q.loop && !$past(seq_start)) |-> !busy); // R6

endmodule

// File: tb/tb_adc_seq_cmp.sv
`timescale 1ns/1ps
module tb_adc_seq_cmp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seq_start = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        seq_done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_seq_cmp dut (
        .clk(clk), .rst(rst), .seq_start(seq_start), .res_valid(res_valid),
        .res_data(res_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_done(seq_done)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic send(input logic [11:0] d);
        @(negedge clk);
        res_valid = 1'b1; res_data = d;
        @(posedge clk); #1;
        res_valid = 1'b0;
    endtask

    task automatic go();
        @(negedge clk);
        seq_start = 1'b1;
        @(posedge clk); #1;
        seq_start = 1'b0;
    endtask

    function automatic logic [11:0] pat(input int l, input int i);
        return 12'((l * 37 + i * 11 + 5) % 4096);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            chk("R1 reset read", v, 16'h0);
        end
        chk("R1 done low", 16'(seq_done), 16'h0);

        // R3 R4 R6: non-FIFO single-shot, all lengths
        for (int l = 1; l <= 16; l++) begin
            wr(5'd16, 16'((l - 1) << 4));
            go();
            for (int i = 0; i < l; i++) begin
                send(pat(l, i));
                if (i == 0 && l > 1) begin
                    rd(5'd20, v);
                    chk("R3 counter advances", v, 16'd1);
                end
                if (i == l - 1) chk("R6 done after last", 16'(seq_done), 16'h1);
                else            chk("R6 no early done", 16'(seq_done), 16'h0);
            end
            @(posedge clk); #1;
            chk("R6 done one cycle", 16'(seq_done), 16'h0);
            rd(5'd20, v);
            chk("R4 counter zero at end", v, 16'h0);
            for (int i = 0; i < l; i++) begin
                rd(5'(i), v);
                chk("R3 stored result", v, 16'(pat(l, i)));
            end
            send(12'hFFF);
            rd(5'd0, v);
            chk("R6 idle result ignored", v, 16'(pat(l, 0)));
            rd(5'd20, v);
            chk("R6 idle counter held", v, 16'h0);
        end

        // R5: FIFO looping scan, 5 per sequence, 20 results
        wr(5'd16, 16'h0043);
        go();
        for (int k = 0; k < 20; k++) begin
            send(12'(k * 3 + 7));
            chk("R5 done per sequence", 16'(seq_done), 16'((k % 5) == 4));
            if (k == 4) begin
                rd(5'd20, v);
                chk("R5 counter carries", v, 16'd5);
            end
        end
        rd(5'd20, v);
        chk("R5 counter wraps", v, 16'd4);
        for (int j = 0; j < 16; j++) begin
            int k;
            k = (j < 4) ? j + 16 : j;
            rd(5'(j), v);
            chk("R5 wrapped store", v, 16'(k * 3 + 7));
        end

        // R7: abort by compare-enable write
        wr(5'd17, 16'h0000);
        rd(5'd20, v);
        chk("R7 abort zeroes counter", v, 16'h0);
        send(12'hABC);
        rd(5'd0, v);
        chk("R7 result after abort ignored", v, 16'(16 * 3 + 7));

        // R2: start clears counter in FIFO mode
        go();
        send(12'd1); send(12'd2); send(12'd3);
        rd(5'd20, v);
        chk("R2 counter before restart", v, 16'd3);
        go();
        rd(5'd20, v);
        chk("R2 start clears in FIFO", v, 16'h0);
        wr(5'd17, 16'h0000);

        // R2: start and result in the same cycle
        wr(5'd16, 16'h0030);
        wr(5'd0, 16'h0123);
        @(negedge clk);
        seq_start = 1'b1; res_valid = 1'b1; res_data = 12'h456;
        @(posedge clk); #1;
        seq_start = 1'b0; res_valid = 1'b0;
        rd(5'd0, v);
        chk("R2 result with start dropped", v, 16'h0123);
        rd(5'd20, v);
        chk("R2 counter zero after start", v, 16'h0);
        wr(5'd17, 16'h0000);

        // R4: non-FIFO loop returns counter to zero each sequence
        wr(5'd16, 16'h0022);
        go();
        send(12'd9); send(12'd8); send(12'd7);
        rd(5'd20, v);
        chk("R4 loop counter zero", v, 16'h0);
        send(12'd6);
        rd(5'd20, v);
        chk("R4 loop next sequence", v, 16'd1);
        rd(5'd0, v);
        chk("R4 loop overwrites reg0", v, 16'd6);
        wr(5'd17, 16'h0000);

        // R9 R10: compare sweep around threshold 100
        for (int s = 0; s < 2; s++) begin
            for (int t = 0; t < 5; t++) begin
                logic [11:0] d;
                logic        exp;
                case (t)
                    0: d = 12'd0;
                    1: d = 12'd99;
                    2: d = 12'd100;
                    3: d = 12'd101;
                    default: d = 12'hFFF;
                endcase
                exp = (s == 1) ? (d > 12'd100) : (d <= 12'd100);
                wr(5'd17, 16'h0001);
                wr(5'd18, 16'(s));
                wr(5'd0, 16'd100);
                wr(5'd16, 16'h0000);
                wr(5'd19, 16'hFFFF);
                go();
                send(d);
                rd(5'd19, v);
                chk("R9 compare flag", v, 16'(exp));
                rd(5'd0, v);
                chk("R10 threshold kept", v, 16'd100);
            end
        end

        // R8: conversion number versus counter in FIFO loop
        wr(5'd17, 16'h0002);
        wr(5'd18, 16'h0002);
        wr(5'd1, 16'd50);
        wr(5'd3, 16'd50);
        wr(5'd16, 16'h0013);
        wr(5'd19, 16'hFFFF);
        go();
        send(12'd10); send(12'd60); send(12'd20); send(12'd40);
        rd(5'd19, v);
        chk("R8 flag by conversion number", v, 16'h0002);
        rd(5'd0, v); chk("R8 uncompared slot0", v, 16'd10);
        rd(5'd1, v); chk("R8 compared slot1", v, 16'd50);
        rd(5'd2, v); chk("R8 uncompared slot2", v, 16'd20);
        rd(5'd3, v); chk("R8 compared slot3", v, 16'd50);

        // R11: set and clear collide, then plain clear
        wr(5'd17, 16'h0001);
        wr(5'd18, 16'h0001);
        wr(5'd0, 16'd100);
        wr(5'd16, 16'h0000);
        wr(5'd19, 16'hFFFF);
        go();
        @(negedge clk);
        res_valid = 1'b1; res_data = 12'd200;
        reg_wr = 1'b1; reg_addr = 5'd19; reg_wdata = 16'h0001;
        @(posedge clk); #1;
        res_valid = 1'b0; reg_wr = 1'b0;
        rd(5'd19, v);
        chk("R11 set wins over clear", v, 16'h0001);
        wr(5'd19, 16'h0002);
        rd(5'd19, v);
        chk("R11 other bit clear no effect", v, 16'h0001);
        wr(5'd19, 16'h0001);
        rd(5'd19, v);
        chk("R11 write one clears", v, 16'h0000);

        // R12: address map details
        wr(5'd5, 16'hFFFF);
        rd(5'd5, v);
        chk("R12 result width", v, 16'h0FFF);
        wr(5'd20, 16'h0005);
        rd(5'd20, v);
        chk("R12 counter read-only", v, 16'h0000);
        wr(5'd25, 16'h1234);
        rd(5'd25, v);
        chk("R12 unused address", v, 16'h0000);
        wr(5'd16, 16'hFFFF);
        rd(5'd16, v);
        chk("R12 control fields", v, 16'h00F3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule